// File: doc/BRIEF.md
# Accumulator Add and Shift Unit with Carry and Overflow Flags

This block is the arithmetic and shift core of a 16-bit accumulator machine. Words are two's complement: a sign bit at the top and fifteen magnitude bits. A caller places an operation code, a memory operand and a shift count on the inputs and pulses `start_i`. Load, add and subtract finish one cycle later. Shifts move the accumulator left by one position per clock, and zeros enter at the low end.

Two flags travel with the accumulator. Carry is rewritten by every add, subtract and shift. Overflow records a signed result that does not fit, and it stays set until the caller clears it. The counting shift is the tool for scanning a status word for its leftmost set bit. It shifts until a one reaches the sign position or the count runs out. Its Carry then reports which of the two happened, and the residual count on `count_o` tells the caller how far it got.

Top module: `acc_shift_unit`

## Requirements
- R1: While reset is asserted and after its release, `acc_o`, `carry_o`, `ovf_o`, `count_o` and `done_o` are all zero.
- R2: Op code 0 (load) copies `operand_i` into the accumulator. Carry and Overflow are unchanged, and `done_o` is high one cycle after the start cycle.
- R3: Op code 1 (add) sets the accumulator to (acc + operand) mod 2^16. Carry becomes the carry out of bit 15, and `done_o` rises one cycle after start.
- R4: Op code 2 (subtract) sets the accumulator to (acc - operand) mod 2^16. Carry becomes 1 exactly when a borrow occurs, which is when the operand, read as unsigned, exceeds the accumulator.
- R5: An add or subtract whose signed result lies outside -32768..32767 sets Overflow. For example, 0x7FFF + 1 gives 0x8000 with Overflow set.
- R6: Overflow is sticky. Load and the shifts leave it unchanged. A high `ovf_clr_i` clears it at the next clock edge, unless an overflow is recorded at that same edge, in which case it stays set.
- R7: Op code 3 (shift left) with count n > 0 shifts one position per clock and fills zeros at the low end. Carry ends as the last bit shifted out of bit 15. `done_o` rises n+1 cycles after start, with `count_o` = 0.
- R8: Op code 4 (counting shift) checks bit 15 before each shift. If bit 15 is 1, the operation stops without shifting, with Carry = 1 and the unused count on `count_o`. After k shifts, `done_o` rises k+2 cycles after start.
- R9: If a counting shift with count n > 0 makes all n shifts without meeting a one in bit 15, it ends with Carry = 0 and `count_o` = 0, and `done_o` rises n+1 cycles after start.
- R10: A shift or counting shift with count 0 raises `done_o` one cycle after start. The accumulator and Carry are unchanged, and `count_o` is 0.
- R11: A `start_i` pulse that arrives while a shift is in progress is ignored, and the running shift completes with its own result.
- R12: Op codes 5, 6 and 7 raise `done_o` one cycle after start and change neither the accumulator nor the flags.
- R13: While no operation is running and `start_i` is low, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin the operation selected by `op_i` |
| op_i | input | 3 | Operation code: 0 load, 1 add, 2 subtract, 3 shift, 4 counting shift |
| operand_i | input | 16 | Memory operand for load, add and subtract |
| count_i | input | 6 | Shift count for both shift operations |
| ovf_clr_i | input | 1 | Clear the sticky Overflow flag at the next edge |
| acc_o | output | 16 | Accumulator |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Sticky Overflow flag |
| count_o | output | 6 | Residual shift count, meaningful when a shift reports done |
| done_o | output | 1 | One-cycle pulse when an operation finishes |

## Verification
The checker assumes that `start_i`, `op_i`, `operand_i`, `count_i` and `ovf_clr_i` are driven to known values whenever the synchronized reset is high. It also assumes that `start_i` is the only thing that can begin work, so the accumulator is expected to hold in every idle cycle without a start. The stimulus meets this by changing inputs only on falling edges, issuing each new operation only after the previous one reports done, and dropping `start_i` after one cycle. The one exception is a deliberate pulse that overlaps a running shift.

// File: rtl/acsu_pkg.sv
package acsu_pkg;
  localparam int unsigned OPW = 3;
  localparam logic [OPW-1:0] OP_LOAD = 3'd0;
  localparam logic [OPW-1:0] OP_ADD  = 3'd1;
  localparam logic [OPW-1:0] OP_SUB  = 3'd2;
  localparam logic [OPW-1:0] OP_SHL  = 3'd3;
  localparam logic [OPW-1:0] OP_SLC  = 3'd4;

  typedef enum logic {ST_IDLE, ST_SHIFT} acsu_state_e;
endpackage

// File: rtl/acsu_rst_sync.sv
module acsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/acsu_addsub.sv
module acsu_addsub #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         vflag_o
);
  logic [W:0] ext;

  always_comb begin
    if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i};
    else       ext = {1'b0, a_i} + {1'b0, b_i};
  end

  assign sum_o  = ext[W-1:0];
  // for subtraction the extra bit is the borrow
  assign cout_o = ext[W];

  always_comb begin
    if (sub_i) vflag_o = (a_i[W-1] != b_i[W-1]) && (ext[W-1] != a_i[W-1]);
    else       vflag_o = (a_i[W-1] == b_i[W-1]) && (ext[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/acsu_shift_step.sv
module acsu_shift_step #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 6
) (
  input  logic [W-1:0]  acc_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          count_mode_i,
  output logic [W-1:0]  acc_o,
  output logic [CW-1:0] cnt_o,
  output logic          carry_o,
  output logic          finish_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_comb begin
    if (count_mode_i && acc_i[W-1]) begin
      // leading one already in the sign position: stop here
      acc_o    = acc_i;
      cnt_o    = cnt_i;
      carry_o  = 1'b1;
      finish_o = 1'b1;
    end else begin
      acc_o    = {acc_i[W-2:0], 1'b0};
      cnt_o    = cnt_i - ONE;
      carry_o  = count_mode_i ? 1'b0 : acc_i[W-1];
      finish_o = (cnt_i == ONE);
    end
  end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acsu_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  operand_i,
  input  logic [CW-1:0] count_i,
  input  logic          ovf_clr_i,
  output logic [W-1:0]  acc_o,
  output logic          carry_o,
  output logic          ovf_o,
  output logic [CW-1:0] count_o,
  output logic          done_o
);
  localparam logic [CW-1:0] CNT_ZERO = '0;

  logic          rst_sn;
  acsu_state_e   st_q, st_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          c_q, c_d, v_q, v_d, mode_q, mode_d, done_q, done_d;
  logic          ovf_set;

  logic [W-1:0]  as_sum;
  logic          as_c, as_v;
  logic [W-1:0]  sh_acc;
  logic [CW-1:0] sh_cnt;
  logic          sh_c, sh_fin;

  acsu_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  acsu_addsub #(.W(W)) u_addsub (
    .a_i     (acc_q),
    .b_i     (operand_i),
    .sub_i   (op_i == OP_SUB),
    .sum_o   (as_sum),
    .cout_o  (as_c),
    .vflag_o (as_v)
  );

  acsu_shift_step #(.W(W), .CW(CW)) u_step (
    .acc_i        (acc_q),
    .cnt_i        (cnt_q),
    .count_mode_i (mode_q),
    .acc_o        (sh_acc),
    .cnt_o        (sh_cnt),
    .carry_o      (sh_c),
    .finish_o     (sh_fin)
  );

  always_comb begin
    st_d    = st_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    c_d     = c_q;
    mode_d  = mode_q;
    done_d  = 1'b0;
    ovf_set = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_d = (op_i == OP_SLC);
          case (op_i)
            OP_LOAD: begin
              acc_d  = operand_i;
              done_d = 1'b1;
            end
            OP_ADD, OP_SUB: begin
              acc_d   = as_sum;
              c_d     = as_c;
              ovf_set = as_v;
              done_d  = 1'b1;
            end
            OP_SHL, OP_SLC: begin
              cnt_d = count_i;
              if (count_i == CNT_ZERO) done_d = 1'b1;
              else                     st_d   = ST_SHIFT;
            end
            default: done_d = 1'b1;
          endcase
        end
      end
      ST_SHIFT: begin
        acc_d = sh_acc;
        cnt_d = sh_cnt;
        c_d   = sh_c;
        if (sh_fin) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    v_d = ovf_set | (v_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      acc_q  <= '0;
      cnt_q  <= '0;
      c_q    <= 1'b0;
      v_q    <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      c_q    <= c_d;
      v_q    <= v_d;
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = c_q;
  assign ovf_o   = v_q;
  assign count_o = cnt_q;
  assign done_o  = done_q;
endmodule

// File: rtl/acsu_chk.sv
module acsu_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          ovf_clr_i,
  input logic [W-1:0]  acc_o,
  input logic          carry_o,
  input logic          ovf_o,
  input logic [CW-1:0] count_o,
  input logic          done_o,
  input logic          busy,
  input logic          slc
);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (count_o == $past(count_o) - 1'b1) ||
             (done_o && count_o == $past(count_o)));

  // R8
  early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && slc && count_o != '0 |-> carry_o && acc_o[W-1]);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy));

  // R13
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !busy |=> $stable(acc_o));
endmodule

bind acc_shift_unit acsu_chk #(.W(W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .start_i   (start_i),
  .ovf_clr_i (ovf_clr_i),
  .acc_o     (acc_o),
  .carry_o   (carry_o),
  .ovf_o     (ovf_o),
  .count_o   (count_o),
  .done_o    (done_o),
  .busy      (st_q == acsu_pkg::ST_SHIFT),
  .slc       (mode_q)
);

// File: tb/acc_shift_unit_tb.sv
module acc_shift_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, ovf_clr_i;
  logic [2:0]  op_i;
  logic [15:0] operand_i;
  logic [5:0]  count_i;
  logic [15:0] acc_o;
  logic        carry_o, ovf_o, done_o;
  logic [5:0]  count_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m_acc = '0;
  logic        m_c = 1'b0, m_v = 1'b0;

  always #5 clk = ~clk;

  acc_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .operand_i(operand_i), .count_i(count_i), .ovf_clr_i(ovf_clr_i),
    .acc_o(acc_o), .carry_o(carry_o), .ovf_o(ovf_o),
    .count_o(count_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic [5:0] n);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return (n == 0) ? "R10" : "R7";
      3'd4: return (n == 0) ? "R10" : "R8/R9";
      default: return "R12";
    endcase
  endfunction

  // one operation, compared with a model built from the requirements
  task automatic run_op(input logic [2:0] op, input logic [15:0] opnd,
                        input logic [5:0] n, input logic clr, input logic inject);
    logic [15:0] e_acc = m_acc;
    logic        e_c = m_c, set = 1'b0;
    logic [16:0] ext;
    int          e_lat = 1, e_cnt = -1, lat, r, k;
    string       tg = tag_of(op, n);
    case (op)
      3'd0: e_acc = opnd;
      3'd1: begin
        ext = {1'b0, m_acc} + {1'b0, opnd};
        e_acc = ext[15:0]; e_c = ext[16];
        set = (m_acc[15] == opnd[15]) && (e_acc[15] != m_acc[15]);
      end
      3'd2: begin
        ext = {1'b0, m_acc} - {1'b0, opnd};
        e_acc = ext[15:0]; e_c = (opnd > m_acc);
        set = (m_acc[15] != opnd[15]) && (e_acc[15] != m_acc[15]);
      end
      3'd3: begin
        e_cnt = 0;
        for (int i = 0; i < int'(n); i++) begin
          e_c = e_acc[15]; e_acc = {e_acc[14:0], 1'b0};
        end
        if (n != 0) e_lat = n + 1;
      end
      3'd4: begin
        e_cnt = 0;
        if (n != 0) begin
          r = n; k = 0;
          while (1) begin
            if (e_acc[15]) begin
              e_c = 1'b1; e_lat = k + 2; e_cnt = r; break;
            end
            e_acc = {e_acc[14:0], 1'b0}; r--; k++;
            if (r == 0) begin
              e_c = 1'b0; e_lat = k + 1; e_cnt = 0; break;
            end
          end
        end
      end
      default: ;
    endcase
    @(negedge clk);
    start_i = 1'b1; op_i = op; operand_i = opnd; count_i = n; ovf_clr_i = clr;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0; ovf_clr_i = 1'b0;
    lat = 1;
    if (inject) begin
      start_i = 1'b1; op_i = 3'd0; operand_i = 16'hDEAD;
    end
    while (!done_o && lat < 200) begin
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat++;
    end
    start_i = 1'b0;
    m_acc = e_acc; m_c = e_c; m_v = set | (m_v & ~clr);
    chk(tg, "done latency", lat, e_lat);
    chk(inject ? "R11" : tg, "acc", acc_o, e_acc);
    chk(tg, "carry", carry_o, e_c);
    chk("R6", "overflow", ovf_o, m_v);
    if (e_cnt >= 0) chk(tg, "count", count_o, e_cnt);
  endtask

  task automatic idle_hold();
    repeat (3) @(negedge clk);
    chk("R13", "acc while idle", acc_o, m_acc);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1130));
    rst_n = 1'b0; start_i = 1'b0; ovf_clr_i = 1'b0;
    op_i = '0; operand_i = '0; count_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", "acc", acc_o, 0);
    chk("R1", "flags", {carry_o, ovf_o, done_o}, 0);
    chk("R1", "count", count_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "acc after release", acc_o, 0);

    // directed corner cases
    run_op(3'd0, 16'h7FFF, 0, 0, 0);        // R2
    run_op(3'd1, 16'h0001, 0, 0, 0);        // R5: 0x7FFF + 1
    chk("R5", "result 0x8000", acc_o, 16'h8000);
    chk("R5", "overflow set", ovf_o, 1);
    run_op(3'd0, 16'h0003, 0, 0, 0);        // R6: load keeps overflow
    run_op(3'd3, 16'h0, 2, 0, 0);           // R6: shift keeps overflow
    run_op(3'd1, 16'h0001, 0, 1, 0);        // R6: clear with no new overflow
    chk("R6", "cleared", ovf_o, 0);
    run_op(3'd0, 16'h8000, 0, 0, 0);
    run_op(3'd2, 16'h0001, 0, 1, 0);        // R6: new overflow wins over clear
    chk("R6", "set wins", ovf_o, 1);
    run_op(3'd0, 16'hFFFF, 0, 0, 0);
    run_op(3'd1, 16'h0001, 0, 0, 0);        // R3: carry out, result 0
    chk("R3", "carry out", carry_o, 1);
    run_op(3'd0, 16'h0001, 0, 0, 0);
    run_op(3'd2, 16'h0002, 0, 0, 0);        // R4: borrow
    chk("R4", "borrow", carry_o, 1);
    run_op(3'd0, 16'hC001, 0, 0, 0);
    run_op(3'd3, 16'h0, 1, 0, 0);           // R7: single shift out of a one
    run_op(3'd0, 16'h0010, 0, 0, 0);
    run_op(3'd4, 16'h0, 20, 0, 0);          // R8: stops after 11 shifts
    chk("R8", "stop carry", carry_o, 1);
    chk("R8", "residual", count_o, 9);
    run_op(3'd4, 16'h0, 5, 0, 0);           // R8: already normalized
    run_op(3'd0, 16'h0100, 0, 0, 0);
    run_op(3'd4, 16'h0, 4, 0, 0);           // R9: count exhausted
    chk("R9", "exhausted carry", carry_o, 0);
    run_op(3'd0, 16'h0000, 0, 0, 0);
    run_op(3'd4, 16'h0, 16, 0, 0);          // R9: zero word
    run_op(3'd0, 16'h8001, 0, 0, 0);
    run_op(3'd3, 16'h0, 0, 0, 0);           // R10
    run_op(3'd4, 16'h0, 0, 0, 0);           // R10
    run_op(3'd0, 16'h0001, 0, 0, 0);
    run_op(3'd3, 16'h0, 6, 0, 1);           // R11: start during shift
    run_op(3'd5, 16'h1234, 3, 0, 0);        // R12
    run_op(3'd7, 16'h4321, 0, 1, 0);        // R12 (clear still honoured)
    idle_hold();                            // R13

    // constrained random
    for (int it = 0; it < 400; it++) begin
      logic [2:0]  op = 3'($urandom % 8);
      logic [15:0] v  = ($urandom % 4 == 0) ? 16'($urandom % 64) : 16'($urandom);
      logic [5:0]  n  = 6'($urandom % 21);
      logic        c  = ($urandom % 8 == 0);
      if ($urandom % 3 == 0) op = 3'($urandom % 3);
      run_op(op, v, n, c, 0);
      if (it % 50 == 0) idle_hold();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule